// File: doc/BRIEF.md
# I2C Slave Transmitter with Double-Buffered Transmit Data

This block is the target side of an I2C bus that answers read requests. It watches the bus for a START condition, collects the first byte after it, and compares the upper seven bits with a programmable own address. On a match it drives a configurable acknowledge level in the ninth clock slot. When the direction bit of that byte asks for a read, the block raises its transmit-mode flag on its own and begins serving data.

Outgoing data passes through two stages. The host writes a byte into a holding register, which clears the buffer-empty flag. The block moves that byte into a shift register at the end of each ninth clock, and at the end of the address acknowledge slot. The move sets the buffer-empty flag again, so the host can queue the next byte while the current one is on the wire. The byte goes out MSB first. The master's acknowledge is sampled and kept as a flag.

If a byte completes and the master acknowledged while no new byte is queued, the block raises the transmit-end flag and holds SCL low. A host write then releases the clock and sends the byte. To end the transfer, the host clears transmit mode and issues a dummy read strobe, which frees SCL and returns the block to idle. A STOP condition also returns it to idle.

Top module: `i2c_slave_tx`

## Requirements
- R1: Only the first byte after a START is compared with the own address. On a mismatch the block never drives SDA low before the next START or STOP, even if a later byte in the same transfer equals the address.
- R2: On a match the block drives SDA to the level on `ack_level` (0 pulls low, 1 leaves the line released) for the whole ninth clock of the address byte.
- R3: On a match, the address byte (address in bits 7:1, direction in bit 0) is captured in `rx_data`. `tx_mode` is set when bit 0 is 1 and stays 0 when bit 0 is 0.
- R4: A host write loads the holding register and clears `tdre`. At the end of the address acknowledge slot, or at the end of a data byte's ninth clock after the master acknowledged, a byte pending in the holding register moves to the shift register and `tdre` returns to 1.
- R5: Data bits leave MSB first. SDA driven by the block changes only while SCL is low. The block releases SDA during the master's acknowledge slot.
- R6: `tend` is set when a data byte's ninth clock ends while `tdre` is 1. It is cleared by a `tend_clr` strobe.
- R7: In transmit mode, if the master acknowledged and `tdre` is 1 when a data byte's ninth clock ends, the block holds SCL low. A host write in that state releases SCL at once, sends the written byte next and leaves `tdre` at 1.
- R8: The sampled master acknowledge bit is kept in `nack` (1 = not acknowledged). After a NACK the block neither drives SDA nor holds SCL until the next START or STOP.
- R9: While SCL is held, clearing transmit mode with `tx_mode_clr` alone keeps SCL held. A following `rx_rd` strobe releases SCL and returns the block to idle.
- R10: A STOP (SDA rising while SCL is high), even in the middle of a byte, clears `tx_mode` and releases both SDA and SCL.
- R11: After reset `tdre` = 1, `tend` = 0, `tx_mode` = 0, `nack` = 0, and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drv_low | output | 1 | 1 pulls SCL low (clock hold) |
| sda_drv_low | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Own slave address |
| ack_level | input | 1 | Level driven in the address acknowledge slot |
| tx_wdata | input | 8 | Byte for the holding register |
| tx_wr | input | 1 | Write strobe for the holding register |
| tend_clr | input | 1 | Clears `tend` |
| tx_mode_clr | input | 1 | Clears `tx_mode` |
| rx_rd | input | 1 | Dummy read strobe of the receive register |
| rx_data | output | 8 | Last matched address byte |
| tx_mode | output | 1 | Transmit-mode flag |
| tdre | output | 1 | Holding register empty |
| tend | output | 1 | Transmission ended with no pending data |
| nack | output | 1 | Last master acknowledge bit sampled (1 = NACK) |

## Verification
The bench queues bytes while the previous byte is still on the wire, so a design that moved data at the wrong time would send a stale or repeated byte. The scoreboard would then flag a mismatch. It also lets a byte run dry so that SCL is held, and checks that only a host write, or the clear-plus-dummy-read sequence, frees the clock. A design that released early, or that required the strobes in a different order, would show the wrong SCL hold state. Other cases send a mismatched address followed by a byte equal to the own address, NACK the last byte and keep clocking, and issue a STOP partway through a byte. A design that rechecked later bytes, kept driving after a NACK, or ignored a STOP mid-byte would show a low SDA or a stuck transmit-mode flag.

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_drv_low,
  output logic       sda_drv_low,
  input  logic [6:0] own_addr,
  input  logic       ack_level,
  input  logic [7:0] tx_wdata,
  input  logic       tx_wr,
  input  logic       tend_clr,
  input  logic       tx_mode_clr,
  input  logic       rx_rd,
  output logic [7:0] rx_data,
  output logic       tx_mode,
  output logic       tdre,
  output logic       tend,
  output logic       nack
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_TX, S_MACK, S_HOLD, S_SKIP} st_t;

  st_t        st;
  logic [1:0] scl_q, sda_q;
  logic       scl_p, sda_p;
  logic [7:0] hold_reg, shf, rsh;
  logic [3:0] bcnt;

  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire start = scl_s & scl_p & sda_p & ~sda_s;
  wire stop  = scl_s & scl_p & ~sda_p & sda_s;
  wire rise  = scl_s & ~scl_p;
  wire fall  = ~scl_s & scl_p;
  wire hit   = (rsh[7:1] == own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_in};
      sda_q <= {sda_q[0], sda_in};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      hold_reg    <= '0;
      shf         <= '0;
      rsh         <= '0;
      bcnt        <= '0;
      rx_data     <= '0;
      tx_mode     <= 1'b0;
      tdre        <= 1'b1;
      tend        <= 1'b0;
      nack        <= 1'b0;
      sda_drv_low <= 1'b0;
      scl_drv_low <= 1'b0;
    end else begin
      if (tend_clr)    tend    <= 1'b0;
      if (tx_mode_clr) tx_mode <= 1'b0;

      if (start) begin
        st          <= S_ADDR;
        bcnt        <= '0;
        sda_drv_low <= 1'b0;
        scl_drv_low <= 1'b0;
      end else if (stop) begin
        st          <= S_IDLE;
        tx_mode     <= 1'b0;
        sda_drv_low <= 1'b0;
        scl_drv_low <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (rise) begin
              rsh  <= {rsh[6:0], sda_s};
              bcnt <= bcnt + 4'd1;
            end else if (fall && bcnt == 4'd8) begin
              if (hit) begin
                rx_data     <= rsh;
                tx_mode     <= rsh[0];
                nack        <= 1'b0;
                sda_drv_low <= ~ack_level;
                st          <= S_AACK;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_AACK: begin
            if (fall) begin
              sda_drv_low <= 1'b0;
              if (!tx_mode) begin
                st <= S_SKIP;
              end else if (!tdre) begin
                shf         <= hold_reg;
                tdre        <= 1'b1;
                sda_drv_low <= ~hold_reg[7];
                bcnt        <= '0;
                st          <= S_TX;
              end else begin
                scl_drv_low <= 1'b1;
                st          <= S_HOLD;
              end
            end
          end
          S_TX: begin
            if (fall) begin
              if (bcnt == 4'd7) begin
                sda_drv_low <= 1'b0;
                st          <= S_MACK;
              end else begin
                shf         <= {shf[6:0], 1'b0};
                sda_drv_low <= ~shf[6];
                bcnt        <= bcnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (rise) begin
              nack <= sda_s;
            end else if (fall) begin
              if (tdre) tend <= 1'b1;
              if (nack) begin
                st <= S_SKIP;
              end else if (!tdre) begin
                shf         <= hold_reg;
                tdre        <= 1'b1;
                sda_drv_low <= ~hold_reg[7];
                bcnt        <= '0;
                st          <= S_TX;
              end else begin
                scl_drv_low <= 1'b1;
                st          <= S_HOLD;
              end
            end
          end
          S_HOLD: begin
            if (tx_wr) begin
              shf         <= tx_wdata;
              sda_drv_low <= ~tx_wdata[7];
              bcnt        <= '0;
              scl_drv_low <= 1'b0;
              st          <= S_TX;
            end else if (!tx_mode && rx_rd) begin
              scl_drv_low <= 1'b0;
              st          <= S_IDLE;
            end
          end
          default: ;
        endcase
      end

      if (tx_wr && st != S_HOLD) begin
        hold_reg <= tx_wdata;
        tdre     <= 1'b0;
      end
    end
  end

  p_sda_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drv_low) |-> !$past(scl_s));

  p_hold_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drv_low |-> tdre);

  p_tend_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend) |-> tdre);

  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!tx_mode && !scl_drv_low && !sda_drv_low));

  p_wr_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !scl_drv_low) |=> !tdre);

  p_nack_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> (!sda_drv_low && !scl_drv_low));

endmodule

// File: tb/i2c_slave_tx_tb.sv
module i2c_slave_tx_tb;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic m_scl = 1, m_sda_low = 0;
  logic scl_drv_low, sda_drv_low;
  logic [6:0] own_addr = OWN;
  logic ack_level = 0;
  logic [7:0] tx_wdata = 0;
  logic tx_wr = 0, tend_clr = 0, tx_mode_clr = 0, rx_rd = 0;
  logic [7:0] rx_data;
  logic tx_mode, tdre, tend, nack;

  wire scl_line = m_scl & ~scl_drv_low;
  wire sda_line = ~(m_sda_low | sda_drv_low);

  i2c_slave_tx u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_drv_low(scl_drv_low), .sda_drv_low(sda_drv_low),
    .own_addr(own_addr), .ack_level(ack_level),
    .tx_wdata(tx_wdata), .tx_wr(tx_wr), .tend_clr(tend_clr),
    .tx_mode_clr(tx_mode_clr), .rx_rd(rx_rd), .rx_data(rx_data),
    .tx_mode(tx_mode), .tdre(tdre), .tend(tend), .nack(nack)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_val;
  event got_byte;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0; @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] b, input bit track);
    tx_wdata = b; tx_wr = 1;
    if (track) exp_q.push_back(b);
    @(negedge clk); tx_wr = 0; @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1; wait_q(Q); m_scl = 0; wait_q(Q);
  endtask

  task automatic m_stop();
    m_scl = 0; m_sda_low = 1; wait_q(Q); m_scl = 1; wait_q(Q); m_sda_low = 0; wait_q(Q);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    int t;
    m_sda_low = ~b; wait_q(Q);
    m_scl = 1;
    t = 0;
    while (!scl_line && t < 2000) begin @(negedge clk); t++; end
    if (!scl_line) chk(0, "R7 scl stuck low", 0, 1);
    wait_q(Q); r = sda_line; wait_q(Q);
    m_scl = 0; wait_q(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, ack);
  endtask

  task automatic read_byte(input logic m_ack, output logic [7:0] v, output logic ackline);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); v[i] = r; end
    clk_bit(m_ack, ackline);
  endtask

  task automatic read_tracked(input logic m_ack, output logic ackline);
    logic [7:0] v;
    read_byte(m_ack, v, ackline);
    got_val = v;
    -> got_byte;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(got_byte);
      if (exp_q.size() == 0) chk(0, "R5 unexpected byte", {24'h0, got_val}, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(got_val == e, "R5 byte order", {24'h0, got_val}, {24'h0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog all", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic a, al;
    logic [7:0] v;
    wait_q(5); rst_n = 1; wait_q(5);

    // R11 reset state
    chk(tdre == 1, "R11 tdre", tdre, 1);
    chk(tend == 0, "R11 tend", tend, 0);
    chk(tx_mode == 0, "R11 tx_mode", tx_mode, 0);
    chk(nack == 0, "R11 nack", nack, 0);
    chk(!sda_drv_low && !scl_drv_low, "R11 lines", {sda_drv_low, scl_drv_low}, 0);

    // R4 write clears tdre
    host_write(8'hA5, 1);
    chk(tdre == 0, "R4 write clears tdre", tdre, 0);

    // R2 R3 R4 address match, read
    m_start();
    send_byte({OWN, 1'b1}, a);
    chk(a == 0, "R2 ack driven low", a, 0);
    chk(tx_mode == 1, "R3 tx_mode set", tx_mode, 1);
    chk(rx_data == {OWN, 1'b1}, "R3 rx_data", rx_data, {OWN, 1'b1});
    chk(tdre == 1, "R4 first transfer", tdre, 1);
    host_write(8'h3C, 1);
    read_tracked(1'b0, al);
    chk(tdre == 1, "R4 second transfer", tdre, 1);
    chk(tend == 0, "R6 tend clear while data pending", tend, 0);
    read_tracked(1'b0, al);
    chk(tend == 1, "R6 tend set", tend, 1);
    chk(scl_drv_low == 1, "R7 scl held", scl_drv_low, 1);
    wait_q(30);
    chk(scl_drv_low == 1, "R7 scl still held", scl_drv_low, 1);
    host_write(8'h81, 1);
    chk(scl_drv_low == 0, "R7 write releases scl", scl_drv_low, 0);
    chk(tdre == 1, "R7 tdre stays 1", tdre, 1);
    pulse(tend_clr);
    chk(tend == 0, "R6 tend_clr", tend, 0);
    read_tracked(1'b1, al);
    chk(al == 1, "R5 ack slot released", al, 1);
    chk(nack == 1, "R8 nack latched", nack, 1);
    chk(scl_drv_low == 0, "R8 no hold after nack", scl_drv_low, 0);
    read_byte(1'b1, v, al);
    chk(v == 8'hFF && al == 1, "R8 no drive after nack", {v, al}, 9'h1FF);
    m_stop();
    chk(tx_mode == 0, "R10 stop clears tx_mode", tx_mode, 0);
    pulse(tend_clr);

    // R1 mismatch then address-like byte
    m_start();
    send_byte({7'h11, 1'b1}, a);
    chk(a == 1, "R1 mismatch no ack", a, 1);
    send_byte({OWN, 1'b1}, a);
    chk(a == 1, "R1 later byte not compared", a, 1);
    chk(tx_mode == 0, "R1 tx_mode stays 0", tx_mode, 0);
    m_stop();

    // R2 ack level 1, R3 write direction
    ack_level = 1;
    m_start();
    send_byte({OWN, 1'b0}, a);
    chk(a == 1, "R2 ack level high", a, 1);
    chk(tx_mode == 0, "R3 write dir no tx", tx_mode, 0);
    chk(rx_data == {OWN, 1'b0}, "R3 rx_data write", rx_data, {OWN, 1'b0});
    m_stop();
    ack_level = 0;

    // R9 end processing
    host_write(8'hC3, 1);
    m_start();
    send_byte({OWN, 1'b1}, a);
    read_tracked(1'b0, al);
    chk(scl_drv_low == 1, "R9 held before end", scl_drv_low, 1);
    pulse(tx_mode_clr);
    chk(tx_mode == 0, "R9 tx_mode cleared", tx_mode, 0);
    chk(scl_drv_low == 1, "R9 still held without read", scl_drv_low, 1);
    pulse(rx_rd);
    chk(scl_drv_low == 0, "R9 read releases scl", scl_drv_low, 0);
    pulse(tend_clr);
    m_stop();

    // R10 stop mid-byte
    host_write(8'hF0, 0);
    m_start();
    send_byte({OWN, 1'b1}, a);
    chk(tx_mode == 1, "R10 tx before stop", tx_mode, 1);
    for (int i = 0; i < 3; i++) begin logic r; clk_bit(1'b1, r); end
    m_stop();
    chk(tx_mode == 0, "R10 mid-byte stop tx_mode", tx_mode, 0);
    chk(!sda_drv_low && !scl_drv_low, "R10 lines released", {sda_drv_low, scl_drv_low}, 0);

    wait_q(5);
    chk(exp_q.size() == 0, "R5 all bytes seen", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule